// File: doc/BRIEF.md
# Action-Gated Trigger Generator

This block supplies the internal trigger signals that a programmable interface state machine uses in its transition equations. Each trigger exists only as a side effect of an action that the current state asserts. Three counters serve the control, address and data channels. A state advances a counter through that channel's count action and re-arms it through an init action. When a counter sits at its programmed limit, the counter raises a hit flag at once. Each counter has its own reload value, counting direction and end-of-count mode, which is either wrap or saturate.

Three masked comparators, one each for the control pins, the address bus and the data bus, report a match when the live value equals a programmed pattern in every bit that the mask selects. A match is reported only while the state being left has enabled that comparison. An interrupt-pending flag is raised by an interrupt action and is held until the host acknowledges it. The sequencer reads all of these flags directly as inputs to its transition logic.

Top module: `trig_event_gen`

## Requirements
- R1: While `rst_n` is low, every counter value is 0 and `irq_pend` is 0.
- R2: A high `cnt_init[i]` at a clock edge loads `cnt_reload[i]` into counter i. It takes priority over `cnt_act[i]` in the same cycle.
- R3: With `cnt_init[i]` low and `cnt_act[i]` high, and the counter not at its limit, the counter moves by exactly one at the edge. It moves up when `cnt_down[i]`=0 and down when `cnt_down[i]`=1, modulo 2^CNT_W. With neither action asserted, the counter holds its value.
- R4: `cnt_hit[i]` is high in exactly those cycles in which `cnt_value[i]` equals `cnt_limit[i]`, with no clock delay.
- R5: In wrap mode (`cnt_wrap[i]`=1), a count action taken while the counter is at its limit reloads `cnt_reload[i]`.
- R6: In saturate mode (`cnt_wrap[i]`=0), a count action taken while the counter is at its limit leaves the value unchanged.
- R7: Index 0 is the control counter, index 1 the address counter and index 2 the data counter. Each counter reacts only to its own action and configuration bits.
- R8: With its enable high, comparator k reports a match exactly when ((value XOR pattern) AND mask) is zero. Mask bits at 0 are ignored. Index k follows the same order: 0 control, 1 address, 2 data.
- R9: While `cmp_en[k]` is low, `cmp_match[k]` is 0 whatever the value, pattern and mask.
- R10: `irq_pend` becomes 1 at the edge after `irq_act` is high. It stays 1 until an edge with `host_ack` high and `irq_act` low clears it.
- R11: When `irq_act` and `host_ack` are both high at one edge, `irq_pend` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_init | input | 3 | Per-counter reload action |
| cnt_act | input | 3 | Per-counter count action |
| cnt_down | input | 3 | Per-counter direction, 1 = down |
| cnt_wrap | input | 3 | Per-counter end mode, 1 = wrap, 0 = saturate |
| cnt_reload | input | 3 x CNT_W | Per-counter reload value |
| cnt_limit | input | 3 x CNT_W | Per-counter limit value |
| cnt_value | output | 3 x CNT_W | Current counter values |
| cnt_hit | output | 3 | Counter at limit |
| cmp_en | input | 3 | Compare action enables (control, address, data) |
| ctl_val | input | CTL_W | Live control pin levels |
| ctl_pat | input | CTL_W | Control pattern |
| ctl_mask | input | CTL_W | Control mask |
| addr_val | input | ADDR_W | Live address |
| addr_pat | input | ADDR_W | Address pattern |
| addr_mask | input | ADDR_W | Address mask |
| data_val | input | DATA_W | Live data |
| data_pat | input | DATA_W | Data pattern |
| data_mask | input | DATA_W | Data mask |
| cmp_match | output | 3 | Qualified compare matches |
| irq_act | input | 1 | Interrupt action from the state |
| host_ack | input | 1 | Host acknowledge strobe |
| irq_pend | output | 1 | Interrupt pending |

## Verification
The hardest case to reach from the ports is a count action that arrives while the counter is already at its limit, because only that case tells wrap mode apart from saturate mode. The counter has to be moved onto the limit first. A related hard case is a down-count that steps through zero. The bench handles both with directed sequences: an init with a reload a few steps short of the limit, or just above zero, followed by a run of count actions. It then runs a random phase with reload and limit drawn from a small range, so that a counter lands on its limit often. Comparator matches are equally hard to hit with random data, so the stimulus builds the live value from the pattern and flips only bits that the mask ignores.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int N_CNT = 3;
  typedef enum int {CH_CTRL = 0, CH_ADDR = 1, CH_DATA = 2} chan_e;
endpackage

// File: rtl/act_counter.sv
module act_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         act,
  input  logic         down,
  input  logic         wrap,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] limit,
  output logic [W-1:0] value,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic         at_limit;
  logic         step_en;
  logic         roll_ev;
  logic         sat_ev;

  function automatic logic [W-1:0] step_val(input logic [W-1:0] cur, input logic dn);
    step_val = dn ? cur - 1'b1 : cur + 1'b1;
  endfunction

  assign at_limit = (cnt_q == limit);
  assign step_en  = act & ~init;
  assign roll_ev  = step_en & at_limit & wrap;
  assign sat_ev   = step_en & at_limit & ~wrap;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (init)    cnt_q <= reload;
    else if (roll_ev) cnt_q <= reload;
    else if (sat_ev)  cnt_q <= cnt_q;
    else if (step_en) cnt_q <= step_val(cnt_q, down);
  end

  assign value = cnt_q;
  assign hit   = at_limit;

  AST_INIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> value == $past(reload)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !act) |=> $stable(value)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !init && !hit && !down) |=> value == $past(value) + 1'b1); // R3
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !init && hit && wrap) |=> value == $past(reload)); // R5
  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !init && hit && !wrap) |=> $stable(value)); // R6
endmodule

// File: rtl/masked_cmp.sv
module masked_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] val,
  input  logic [W-1:0] pat,
  input  logic [W-1:0] mask,
  output logic         match
);
  logic eq_raw;

  function automatic logic masked_eq(input logic [W-1:0] a, input logic [W-1:0] b,
                                     input logic [W-1:0] m);
    masked_eq = ~|((a ^ b) & m);
  endfunction

  assign eq_raw = masked_eq(val, pat, mask);
  assign match  = en & eq_raw;

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !match); // R9
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mask == '0) |-> match); // R8
  AST_EXACT_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (en && val == pat) |-> match); // R8
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic pend
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (ack) pend_q <= 1'b0;
  end

  assign pend = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !pend); // R10
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !set) |=> $stable(pend)); // R10
endmodule

// File: rtl/trig_event_gen.sv
module trig_event_gen
  import trig_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CTL_W  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CNT-1:0]            cnt_init,
  input  logic [N_CNT-1:0]            cnt_act,
  input  logic [N_CNT-1:0]            cnt_down,
  input  logic [N_CNT-1:0]            cnt_wrap,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_reload,
  input  logic [N_CNT-1:0][CNT_W-1:0] cnt_limit,
  output logic [N_CNT-1:0][CNT_W-1:0] cnt_value,
  output logic [N_CNT-1:0]            cnt_hit,
  input  logic [N_CNT-1:0]            cmp_en,
  input  logic [CTL_W-1:0]            ctl_val,
  input  logic [CTL_W-1:0]            ctl_pat,
  input  logic [CTL_W-1:0]            ctl_mask,
  input  logic [ADDR_W-1:0]           addr_val,
  input  logic [ADDR_W-1:0]           addr_pat,
  input  logic [ADDR_W-1:0]           addr_mask,
  input  logic [DATA_W-1:0]           data_val,
  input  logic [DATA_W-1:0]           data_pat,
  input  logic [DATA_W-1:0]           data_mask,
  output logic [N_CNT-1:0]            cmp_match,
  input  logic                        irq_act,
  input  logic                        host_ack,
  output logic                        irq_pend
);
  // R7: one counter per channel, each tied only to its own slice
  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    act_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (cnt_init[i]),
      .act    (cnt_act[i]),
      .down   (cnt_down[i]),
      .wrap   (cnt_wrap[i]),
      .reload (cnt_reload[i]),
      .limit  (cnt_limit[i]),
      .value  (cnt_value[i]),
      .hit    (cnt_hit[i])
    );
  end

  masked_cmp #(.W(CTL_W)) u_cmp_ctl (
    .clk(clk), .rst_n(rst_n), .en(cmp_en[CH_CTRL]),
    .val(ctl_val), .pat(ctl_pat), .mask(ctl_mask), .match(cmp_match[CH_CTRL])
  );

  masked_cmp #(.W(ADDR_W)) u_cmp_addr (
    .clk(clk), .rst_n(rst_n), .en(cmp_en[CH_ADDR]),
    .val(addr_val), .pat(addr_pat), .mask(addr_mask), .match(cmp_match[CH_ADDR])
  );

  masked_cmp #(.W(DATA_W)) u_cmp_data (
    .clk(clk), .rst_n(rst_n), .en(cmp_en[CH_DATA]),
    .val(data_val), .pat(data_pat), .mask(data_mask), .match(cmp_match[CH_DATA])
  );

  irq_flag u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_act), .ack(host_ack), .pend(irq_pend)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (cnt_value == '0 && !irq_pend)); // R1
endmodule

// File: tb/tb_trig_event_gen.sv
module tb_trig_event_gen;
  localparam int CW = 16;
  localparam int TW = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                 rst_n;
  logic [2:0]           cnt_init, cnt_act, cnt_down, cnt_wrap;
  logic [2:0][CW-1:0]   cnt_reload, cnt_limit, cnt_value;
  logic [2:0]           cnt_hit, cmp_en, cmp_match;
  logic [TW-1:0]        ctl_val, ctl_pat, ctl_mask;
  logic [AW-1:0]        addr_val, addr_pat, addr_mask;
  logic [DW-1:0]        data_val, data_pat, data_mask;
  logic                 irq_act, host_ack, irq_pend;

  trig_event_gen #(.CNT_W(CW), .CTL_W(TW), .ADDR_W(AW), .DATA_W(DW)) dut (.*);

  int total = 0;
  int bad   = 0;
  int m_cnt [3];
  string m_tag [3];
  bit    m_pend;
  string m_ptag;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic bit exp_match(int k);
    logic [63:0] v, p, m;
    case (k)
      0: begin v = 64'(ctl_val);  p = 64'(ctl_pat);  m = 64'(ctl_mask);  end
      1: begin v = 64'(addr_val); p = 64'(addr_pat); m = 64'(addr_mask); end
      default: begin v = 64'(data_val); p = 64'(data_pat); m = 64'(data_mask); end
    endcase
    return cmp_en[k] && (((v ^ p) & m) == 64'd0);
  endfunction

  task automatic check_all();
    for (int i = 0; i < 3; i++) begin
      chk(m_tag[i], $sformatf("value[%0d]", i), 64'(cnt_value[i]), 64'(m_cnt[i]));
      chk("R4", $sformatf("hit[%0d]", i), 64'(cnt_hit[i]),
          64'(m_cnt[i] == int'(cnt_limit[i])));
    end
    for (int k = 0; k < 3; k++)
      chk(cmp_en[k] ? "R8" : "R9", $sformatf("match[%0d]", k),
          64'(cmp_match[k]), 64'(exp_match(k)));
    chk(m_ptag, "irq_pend", 64'(irq_pend), 64'(m_pend));
  endtask

  // reference update using the inputs that the coming edge will see
  task automatic advance();
    for (int i = 0; i < 3; i++) begin
      if (cnt_init[i]) begin
        m_cnt[i] = int'(cnt_reload[i]); m_tag[i] = "R2";
      end else if (cnt_act[i]) begin
        if (m_cnt[i] == int'(cnt_limit[i])) begin
          if (cnt_wrap[i]) begin m_cnt[i] = int'(cnt_reload[i]); m_tag[i] = "R5"; end
          else m_tag[i] = "R6";
        end else begin
          m_cnt[i] = cnt_down[i] ? (m_cnt[i] + 65535) % 65536 : (m_cnt[i] + 1) % 65536;
          m_tag[i] = "R3";
        end
      end else m_tag[i] = "R7";
    end
    if (irq_act) begin m_pend = 1'b1; m_ptag = host_ack ? "R11" : "R10"; end
    else if (host_ack) begin m_pend = 1'b0; m_ptag = "R10"; end
    else m_ptag = "R10";
  endtask

  task automatic cycle();
    advance();
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    cnt_init = '0; cnt_act = '0; irq_act = 1'b0; host_ack = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); cnt_down = '0; cnt_wrap = '0;
    cnt_reload = '0; cnt_limit = '0; cmp_en = '0;
    ctl_val = '0; ctl_pat = '0; ctl_mask = '0;
    addr_val = '0; addr_pat = '0; addr_mask = '0;
    data_val = '0; data_pat = '0; data_mask = '0;
    cnt_limit[0] = 16'd3; cnt_limit[1] = 16'd3; cnt_limit[2] = 16'd3;
    // R1: drive actions while in reset, they must not take effect
    cnt_act = 3'b111; irq_act = 1'b1;
    repeat (3) @(negedge clk);
    quiet();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_tag[i] = "R1"; end
    m_pend = 1'b0; m_ptag = "R1";
    check_all();

    // R5: control counter, reload 5, limit 8, up, wrap
    cnt_reload[0] = 16'd5; cnt_limit[0] = 16'd8; cnt_wrap[0] = 1'b1; cnt_down[0] = 1'b0;
    cnt_init[0] = 1'b1; cycle(); cnt_init[0] = 1'b0;
    cnt_act[0] = 1'b1; repeat (10) cycle(); cnt_act = '0;

    // R3 and R6: address counter counts down through zero, saturates at its limit
    cnt_reload[1] = 16'd1; cnt_limit[1] = 16'hFFFD; cnt_down[1] = 1'b1; cnt_wrap[1] = 1'b0;
    cnt_init[1] = 1'b1; cycle(); cnt_init[1] = 1'b0;
    cnt_act[1] = 1'b1; repeat (7) cycle(); cnt_act = '0;

    // R2: init and act together, init wins
    cnt_reload[2] = 16'd40; cnt_limit[2] = 16'd42; cnt_wrap[2] = 1'b0;
    cnt_init[2] = 1'b1; cnt_act[2] = 1'b1; cycle();
    cnt_init[2] = 1'b0; repeat (4) cycle(); cnt_act = '0;
    repeat (2) cycle();

    // R10 and R11: interrupt flag
    irq_act = 1'b1; cycle(); irq_act = 1'b0; repeat (3) cycle();
    host_ack = 1'b1; cycle(); host_ack = 1'b0; cycle();
    irq_act = 1'b1; host_ack = 1'b1; cycle(); quiet(); cycle();
    host_ack = 1'b1; cycle(); quiet(); cycle();

    // R8 and R9: comparators with empty mask, exact match, disabled
    cmp_en = 3'b111; ctl_mask = '0; addr_mask = '0; data_mask = '0;
    ctl_val = 8'hA5; addr_val = 16'h1234; data_val = 32'hDEADBEEF; cycle();
    ctl_mask = '1; ctl_pat = 8'hA5; addr_mask = '1; addr_pat = 16'h1235;
    data_mask = 32'hFFFF0000; data_pat = 32'hDEAD0000; cycle();
    cmp_en = 3'b000; cycle();

    // random phase: all channels at once
    for (int n = 0; n < 4000; n++) begin
      for (int i = 0; i < 3; i++) begin
        cnt_init[i] = ($urandom_range(15) == 0);
        cnt_act[i]  = $urandom_range(1);
        if ($urandom_range(7) == 0) begin
          cnt_down[i] = $urandom_range(1);
          cnt_wrap[i] = $urandom_range(1);
        end
        if (cnt_init[i]) begin
          cnt_reload[i] = ($urandom_range(9) == 0) ? 16'hFFFE : CW'($urandom_range(7));
          cnt_limit[i]  = ($urandom_range(9) == 0) ? 16'hFFFF : CW'($urandom_range(7));
        end
      end
      cmp_en    = 3'($urandom_range(7));
      ctl_pat   = TW'($urandom);  ctl_mask  = TW'($urandom);
      addr_pat  = AW'($urandom);  addr_mask = AW'($urandom);
      data_pat  = $urandom;       data_mask = $urandom;
      if ($urandom_range(1) == 1) begin
        ctl_val  = ctl_pat  ^ (TW'($urandom) & ~ctl_mask);
        addr_val = addr_pat ^ (AW'($urandom) & ~addr_mask);
        data_val = data_pat ^ ($urandom & ~data_mask);
      end else begin
        ctl_val = TW'($urandom); addr_val = AW'($urandom); data_val = $urandom;
      end
      irq_act  = ($urandom_range(7) == 0);
      host_ack = ($urandom_range(3) == 0);
      cycle();
    end

    quiet();
    cycle();
    summary();
    $finish;
  end
endmodule